// File: doc/BRIEF.md
# Clocked Sequential Buffer Port with End-of-Buffer Flags

This block is the clocked, streaming side of a word-organised buffer. An address counter walks through a private storage array on the rising edge of the port clock. Each edge can read the word at the counter, write the input word there, or do neither. A pointer load places the counter at a programmed start address. Two independent comparators watch the counter. Each one pulls its active-low flag when the counter steps onto that flag's programmed end address.

The counter has its own active-low enable, separate from the port select. It therefore keeps stepping while the port is deselected. When the enable is active, the step happens first, and the access in the same edge then uses the stepped address. Read data leaves the block as a word plus a drive qualifier, which the pad ring uses as its output enable. A strobe from the random-access side that reaches the command register while this port is selected is reported as a protocol error and otherwise ignored.

Top module: `seqp_port`

## Requirements
- R1: An edge with `rst_n` low loads the counter from `start_ptr`, sets both flags high and clears `rd_drive` and `proto_err`. This holds even if the start equals an end address.
- R2: With `ld_n` high and `cnt_en_n` low, each edge adds one to the counter, wrapping from all ones to zero. The read or write in that edge uses the new address.
- R3: With `ld_n` high and `cnt_en_n` high, the counter and both flags keep their values.
- R4: With the port selected (`sel_n` low), `rd_wr_n` high and `oe_n` low, after the edge `rd_drive` is 1 and `rdata` holds the word at the counter.
- R5: With `oe_n` high, `rd_drive` is 0 and `rdata` is all zeros after the edge. The counter still advances when enabled.
- R6: With the port selected and `rd_wr_n` low, `wdata` is stored at the counter address in use at that edge. A later read returns it.
- R7: With `sel_n` high, nothing is written and `rd_drive` is 0. The counter still advances or holds as `cnt_en_n` dictates.
- R8: `eob1_n` goes low after an advancing edge whose new address equals `end1_ptr`. It then stays low until reset or load.
- R9: `eob2_n` behaves the same way against `end2_ptr`, independently of `eob1_n`.
- R10: With `ld_n` low, the counter takes `start_ptr` and both flags return high. No read or write happens. Load takes priority over advance.
- R11: `proto_err` is high for the cycle after each edge at which `cmd_access` is high and `sel_n` is low, and low otherwise. `cmd_access` has no other effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| sel_n | input | 1 | Port select, active low |
| cnt_en_n | input | 1 | Counter advance enable, active low |
| rd_wr_n | input | 1 | 1 = read, 0 = write |
| oe_n | input | 1 | Read output enable, active low |
| ld_n | input | 1 | Pointer load, active low |
| start_ptr | input | ADDR_W | Start address for reset and load |
| end1_ptr | input | ADDR_W | First end-of-buffer address |
| end2_ptr | input | ADDR_W | Second end-of-buffer address |
| wdata | input | DATA_W | Write data |
| cmd_access | input | 1 | Strobe from the random port to the command register |
| rdata | output | DATA_W | Read data, zero when not driven |
| rd_drive | output | 1 | Read data valid / pad output enable |
| seq_addr | output | ADDR_W | Current counter value |
| eob1_n | output | 1 | First end-of-buffer flag, active low |
| eob2_n | output | 1 | Second end-of-buffer flag, active low |
| proto_err | output | 1 | Random-port command access collided with this port |

## Verification
Two functions share one edge: the counter step and the access, and within the step the flag comparison. The bench runs full write and read sweeps with the enable held low across the wrap. The first access after reset must therefore land one past the start address, and a flag must drop in exactly the cycle the access reaches its end address. A load is also issued together with a selected write request, and the bench checks that the word under the new start pointer is unchanged. Expected words, addresses and flags come from an arithmetic model in the bench.

// File: rtl/seqp_pkg.sv
package seqp_pkg;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2,
        OP_LOAD  = 2'd3
    } seq_op_e;

    // Load wins over any access; a deselected port performs no access.
    function automatic seq_op_e seqp_decode(input logic sel_n, input logic ld_n,
                                            input logic rd_wr_n);
        if (!ld_n)
            return OP_LOAD;
        else if (sel_n)
            return OP_IDLE;
        else if (rd_wr_n)
            return OP_READ;
        else
            return OP_WRITE;
    endfunction

endpackage

// File: rtl/seqp_addr_step.sv
module seqp_addr_step #(
    parameter int ADDR_W = 10
) (
    input  logic [ADDR_W-1:0] cur,
    input  logic              advance,
    output logic [ADDR_W-1:0] nxt
);
    // Natural modulo arithmetic gives the wrap from all ones to zero.
    always_comb begin
        nxt = cur;
        if (advance)
            nxt = cur + ADDR_W'(1);
    end
endmodule

// File: rtl/seqp_eob_cmp.sv
module seqp_eob_cmp #(
    parameter int ADDR_W = 10,
    parameter int N_EOB  = 2
) (
    input  logic [ADDR_W-1:0]             addr_nxt,
    input  logic                          advance,
    input  logic [N_EOB-1:0][ADDR_W-1:0]  ends,
    output logic [N_EOB-1:0]              hit
);
    for (genvar i = 0; i < N_EOB; i++) begin : g_cmp
        assign hit[i] = advance && (addr_nxt == ends[i]);
    end
endmodule

// File: rtl/seqp_store.sv
module seqp_store #(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              we,
    input  logic              re,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we)
            mem[addr] <= wdata;
        if (re)
            rdata <= mem[addr];
    end
endmodule

// File: rtl/seqp_port.sv
module seqp_port
    import seqp_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_n,
    input  logic              cnt_en_n,
    input  logic              rd_wr_n,
    input  logic              oe_n,
    input  logic              ld_n,
    input  logic [ADDR_W-1:0] start_ptr,
    input  logic [ADDR_W-1:0] end1_ptr,
    input  logic [ADDR_W-1:0] end2_ptr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              cmd_access,
    output logic [DATA_W-1:0] rdata,
    output logic              rd_drive,
    output logic [ADDR_W-1:0] seq_addr,
    output logic              eob1_n,
    output logic              eob2_n,
    output logic              proto_err
);
    localparam int N_EOB = 2;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [N_EOB-1:0]  eob_n;
        logic              drive;
        logic              perr;
    } seq_state_t;

    seq_state_t st_d, st_q;

    seq_op_e                     op;
    logic                        advance;
    logic [ADDR_W-1:0]           addr_nxt;
    logic [N_EOB-1:0]            hit;
    logic [N_EOB-1:0][ADDR_W-1:0] ends;
    logic                        mem_we;
    logic                        mem_re;
    logic [DATA_W-1:0]           mem_q;

    assign op      = seqp_decode(sel_n, ld_n, rd_wr_n);
    assign advance = (op != OP_LOAD) && !cnt_en_n;
    assign ends    = {end2_ptr, end1_ptr};

    seqp_addr_step #(.ADDR_W(ADDR_W)) u_step (
        .cur     (st_q.addr),
        .advance (advance),
        .nxt     (addr_nxt)
    );

    seqp_eob_cmp #(.ADDR_W(ADDR_W), .N_EOB(N_EOB)) u_eob (
        .addr_nxt (addr_nxt),
        .advance  (advance),
        .ends     (ends),
        .hit      (hit)
    );

    // Access uses the stepped address: the increment comes first.
    seqp_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
        .clk   (clk),
        .we    (mem_we),
        .re    (mem_re),
        .addr  (addr_nxt),
        .wdata (wdata),
        .rdata (mem_q)
    );

    always_comb begin
        st_d   = st_q;
        mem_we = rst_n && (op == OP_WRITE);
        mem_re = rst_n && (op == OP_READ);
        if (!rst_n) begin
            st_d.addr  = start_ptr;
            st_d.eob_n = '1;
            st_d.drive = 1'b0;
            st_d.perr  = 1'b0;
        end else if (op == OP_LOAD) begin
            st_d.addr  = start_ptr;
            st_d.eob_n = '1;
            st_d.drive = 1'b0;
            st_d.perr  = cmd_access && !sel_n;
        end else begin
            st_d.addr  = addr_nxt;
            st_d.eob_n = st_q.eob_n & ~hit;
            st_d.drive = (op == OP_READ) && !oe_n;
            st_d.perr  = cmd_access && !sel_n;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign seq_addr  = st_q.addr;
    assign eob1_n    = st_q.eob_n[0];
    assign eob2_n    = st_q.eob_n[1];
    assign rd_drive  = st_q.drive;
    assign rdata     = st_q.drive ? mem_q : '0;
    assign proto_err = st_q.perr;

endmodule

// File: rtl/seqp_port_chk.sv
module seqp_port_chk #(
    parameter int ADDR_W = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sel_n,
    input logic              cnt_en_n,
    input logic              oe_n,
    input logic              ld_n,
    input logic              cmd_access,
    input logic [ADDR_W-1:0] end1_ptr,
    input logic [ADDR_W-1:0] end2_ptr,
    input logic              rd_drive,
    input logic [ADDR_W-1:0] seq_addr,
    input logic              eob1_n,
    input logic              eob2_n,
    input logic              proto_err
);
    assert_reset_state_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (eob1_n && eob2_n && !rd_drive && !proto_err));

    assert_advance_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_en_n && ld_n) |=> (seq_addr == ADDR_W'($past(seq_addr) + 1'b1)));

    assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_en_n && ld_n) |=> ($stable(seq_addr) && $stable(eob1_n) && $stable(eob2_n)));

    assert_no_drive_oe_R5: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |=> !rd_drive);

    assert_no_drive_desel_R7: assert property (@(posedge clk) disable iff (!rst_n)
        sel_n |=> !rd_drive);

    assert_eob1_hit_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_en_n && ld_n && (ADDR_W'(seq_addr + 1'b1) == end1_ptr)) |=> !eob1_n);

    assert_eob1_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!eob1_n && ld_n) |=> !eob1_n);

    assert_eob2_hit_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_en_n && ld_n && (ADDR_W'(seq_addr + 1'b1) == end2_ptr)) |=> !eob2_n);

    assert_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_n |=> (eob1_n && eob2_n && !rd_drive));

    assert_perr_set_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_access && !sel_n) |=> proto_err);

    assert_perr_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_access && !sel_n) |=> !proto_err);
endmodule

bind seqp_port seqp_port_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sel_n      (sel_n),
    .cnt_en_n   (cnt_en_n),
    .oe_n       (oe_n),
    .ld_n       (ld_n),
    .cmd_access (cmd_access),
    .end1_ptr   (end1_ptr),
    .end2_ptr   (end2_ptr),
    .rd_drive   (rd_drive),
    .seq_addr   (seq_addr),
    .eob1_n     (eob1_n),
    .eob2_n     (eob2_n),
    .proto_err  (proto_err)
);

// File: tb/seqp_port_tb.sv
module seqp_port_tb;
    localparam int AW    = 4;
    localparam int DW    = 8;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sel_n = 1'b1, cnt_en_n = 1'b1, rd_wr_n = 1'b1, oe_n = 1'b1, ld_n = 1'b1;
    logic          cmd_access = 1'b0;
    logic [AW-1:0] start_ptr = '0, end1_ptr = '0, end2_ptr = '0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rdata;
    logic          rd_drive, eob1_n, eob2_n, proto_err;
    logic [AW-1:0] seq_addr;

    always #5 clk = ~clk;

    seqp_port #(.ADDR_W(AW), .DATA_W(DW)) u_dut (
        .clk, .rst_n, .sel_n, .cnt_en_n, .rd_wr_n, .oe_n, .ld_n,
        .start_ptr, .end1_ptr, .end2_ptr, .wdata, .cmd_access,
        .rdata, .rd_drive, .seq_addr, .eob1_n, .eob2_n, .proto_err
    );

    int n_chk  = 0;
    int n_fail = 0;

    logic [DW-1:0] m_mem [DEPTH];
    logic [AW-1:0] m_addr;
    logic          m_f1, m_f2, m_drv, m_perr;
    logic [DW-1:0] m_rq;

    task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic compare(string tag);
        check(tag, "seq_addr", 32'(seq_addr), 32'(m_addr));
        check(tag, "eob1_n", 32'(eob1_n), 32'(m_f1));
        check(tag, "eob2_n", 32'(eob2_n), 32'(m_f2));
        check(tag, "rd_drive", 32'(rd_drive), 32'(m_drv));
        check(tag, "rdata", 32'(rdata), m_drv ? 32'(m_rq) : 32'd0);
        check(tag, "proto_err", 32'(proto_err), 32'(m_perr));
    endtask

    task automatic do_reset(string tag);
        @(negedge clk);
        rst_n = 1'b0; sel_n = 1'b1; cnt_en_n = 1'b1; ld_n = 1'b1; cmd_access = 1'b0;
        repeat (2) @(posedge clk);
        m_addr = start_ptr; m_f1 = 1'b1; m_f2 = 1'b1; m_drv = 1'b0; m_perr = 1'b0;
        #2 compare(tag);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic step(string tag, logic s_n, logic c_n, logic rw, logic o_n,
                        logic l_n, logic cmd, logic [DW-1:0] wd);
        logic [AW-1:0] op;
        @(negedge clk);
        sel_n = s_n; cnt_en_n = c_n; rd_wr_n = rw; oe_n = o_n; ld_n = l_n;
        cmd_access = cmd; wdata = wd;
        @(posedge clk);
        if (!l_n) begin
            m_addr = start_ptr; m_f1 = 1'b1; m_f2 = 1'b1; m_drv = 1'b0;
        end else begin
            op = c_n ? m_addr : m_addr + 1'b1;
            m_addr = op;
            if (!c_n) begin
                if (op == end1_ptr) m_f1 = 1'b0;
                if (op == end2_ptr) m_f2 = 1'b0;
            end
            if (!s_n && !rw) m_mem[op] = wd;
            if (!s_n && rw) m_rq = m_mem[op];
            m_drv = !s_n && rw && !o_n;
        end
        m_perr = cmd && !s_n;
        #2 compare(tag);
    endtask

    initial begin
        #(200_000 * 10);
        n_fail++;
        $display("FAIL R1 watchdog actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        start_ptr = 4'd3; end1_ptr = 4'd9; end2_ptr = 4'd14;
        do_reset("R1");

        // Advancing write sweep across the wrap; first write lands at start+1.
        for (int i = 0; i < DEPTH; i++)
            step("R2 R6 R8 R9", 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, DW'(i * 37 + 11));

        step("R10", 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, '0);

        for (int i = 0; i < DEPTH; i++)
            step("R4 R8 R9", 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, '0);

        repeat (3) step("R3", 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, '0);

        step("R6", 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 8'hA5);
        step("R6", 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, '0);

        repeat (4) step("R5", 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, '0);

        for (int i = 0; i < 5; i++)
            step("R7", 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 8'h5A);
        repeat (2) step("R7", 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 8'h66);

        // Read back everything: deselected writes must have left no trace.
        step("R10", 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, '0);
        for (int i = 0; i < DEPTH; i++)
            step("R7 R4", 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, '0);

        step("R11", 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, '0);
        step("R11", 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, '0);
        step("R11", 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, '0);

        // Load alongside a selected advancing write: no write, no advance.
        start_ptr = 4'd12;
        step("R10", 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'hFF);
        step("R10", 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, '0);

        // Reset onto an end address, then wrap all the way round.
        start_ptr = 4'd7; end1_ptr = 4'd7; end2_ptr = 4'd0;
        do_reset("R1");
        for (int i = 0; i < DEPTH + 2; i++)
            step("R2 R4 R8 R9", 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, '0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule